// File: doc/BRIEF.md
# Master Serial Audio Transmitter

This block is the transmit side of a stereo serial audio link on which the block is the clock master. It divides the system clock to make a bit clock and counts bit clocks to make a word clock. Both clocks leave the block as outputs. One stereo PCM sample per frame is shifted out on a single data line, most significant bit first. The sample is fetched from a parallel input through a ready/valid handshake.

Two framings are offered, and a run-time input selects between them. In the first, the word clock is low for the left channel and high for the right channel, and each word starts one bit clock after the word clock edge (I2S). In the second, the word clock is high for the left channel and low for the right channel, and each word starts on the first bit clock of its slot (Left-Justified). The format is taken at each frame start, so a frame is never sent in a mix of the two.

Three parameters set the timing. The half period of the bit clock in system clocks, the number of bit clocks in a channel slot and the sample width are all parameters. The sample width must be below the slot length, which leaves room for the one-bit delay of I2S.

Top module: `audio_master_tx`

## Requirements
- R1: `bclk` is low after reset and toggles every DIV_HALF system clocks, with a period of 2*DIV_HALF system clocks and equal high and low times.
- R2: `wclk` and `sdata` change only in the system cycle in which `bclk` falls.
- R3: With I2S selected (`fmt_lj`=0), `wclk` is 0 during the left slot and 1 during the right slot. Sample bit W-1 is sent on the second bit clock of the slot, and the first bit of the slot is 0.
- R4: With Left-Justified selected (`fmt_lj`=1), `wclk` is 1 during the left slot and 0 during the right slot. Sample bit W-1 is sent on the first bit clock of the slot.
- R5: Each word is sent MSB first, one bit per bit clock, with all W bits present. Every slot bit after the LSB is 0.
- R6: A slot is SLOT_BITS bit clocks long. Two changes of `wclk` are never fewer than SLOT_BITS bit clocks apart.
- R7: `smp_ready` is high for exactly one system cycle per frame. That cycle is the one just before the falling `bclk` edge that opens the left slot. The sample on `smp_left`/`smp_right` is taken in that cycle if `smp_valid` is 1.
- R8: If `smp_valid` is 0 in the ready cycle, the whole frame carries zeros. A `smp_valid` pulse outside the ready cycle has no effect on the data sent.
- R9: `fmt_lj` is sampled in the ready cycle and holds for the whole frame. A change in the middle of a frame first shows in the next frame.
- R10: During reset, `bclk`=0, `sdata`=0 and `smp_ready`=0. `wclk` sits at the left-channel level of the selected format: 1 for Left-Justified and 0 for I2S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_lj | input | 1 | Format select: 0 = I2S, 1 = Left-Justified |
| smp_valid | input | 1 | A stereo sample is offered |
| smp_left | input | SAMPLE_W | Left channel sample |
| smp_right | input | SAMPLE_W | Right channel sample |
| smp_ready | output | 1 | Sample accepted this cycle if valid |
| bclk | output | 1 | Generated bit clock |
| wclk | output | 1 | Generated word clock |
| sdata | output | 1 | Serial data, changes on falling bclk |

## Verification
Three events can fall in the same system cycle: the sample handshake, the format capture at the frame boundary and the falling bit clock edge that sends the first bit of the new frame. The bench provokes this by toggling `fmt_lj` in the very ready cycle of some frames. It also withholds `smp_valid` only in the ready cycle of other frames, while holding it high with junk data in all cycles around it. A behavioural model predicts the level of every output in every cycle from the values it saw in the ready cycle. Any stale format, any captured junk and any missing zero frame then shows as a mismatch on `wclk` or `sdata`.

// File: rtl/amtx_pkg.sv
// Shared types for the master serial audio transmitter.
package amtx_pkg;
    // Frame format; the encoding matches the fmt_lj port.
    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } fmt_e;
endpackage

// File: rtl/amtx_bclk_gen.sv
// Bit clock generator.
// Divides the system clock by 2*DIV_HALF to make the bit clock. It flags the
// cycle before each falling edge so that other logic can update on that edge.
// Assumes DIV_HALF >= 1. The output is low out of reset.
module amtx_bclk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic fall_tick
);
    generate
        if (DIV_HALF == 1) begin : g_nodiv
            // Toggle the bit clock every system cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) bclk <= 1'b0;
                else        bclk <= ~bclk;
            end
            assign fall_tick = bclk;
        end else begin : g_div
            localparam int CW = $clog2(DIV_HALF);
            localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
            logic [CW-1:0] cnt_q;
            logic          last;
            assign last = (cnt_q == LAST);
            // Count system cycles in each half period and toggle at its end.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                    bclk  <= 1'b0;
                end else begin
                    cnt_q <= last ? '0 : cnt_q + 1'b1;
                    if (last) bclk <= ~bclk;
                end
            end
            assign fall_tick = last & bclk;
        end
    endgenerate
endmodule

// File: rtl/amtx_frame_seq.sv
// Frame sequencer.
// Tracks the bit position inside a frame of 2*SLOT_BITS bit clocks. It drives
// the word clock and latches the format once per frame. It reports the
// channel and slot offset of the bit that the coming falling edge will send.
// Assumes SLOT_BITS >= 2. Out of reset the position sits on the last bit of
// the frame, so the first falling edge opens a left slot.
module amtx_frame_seq
    import amtx_pkg::*;
#(
    parameter  int SLOT_BITS = 32,
    localparam int OFF_W     = $clog2(SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_tick,
    input  fmt_e             fmt_in,
    output logic             frame_start,
    output logic             wclk,
    output fmt_e             fmt_cur,
    output logic             nxt_right,
    output logic [OFF_W-1:0] nxt_off
);
    localparam int FRAME = 2 * SLOT_BITS;
    localparam int POS_W = $clog2(FRAME);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME - 1);
    localparam logic [POS_W-1:0] SLOT_POS = POS_W'(SLOT_BITS);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] nxt_pos;
    fmt_e             fmt_q;

    assign nxt_pos     = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    assign frame_start = fall_tick && (pos_q == LAST_POS);
    assign nxt_right   = (nxt_pos >= SLOT_POS);
    assign nxt_off     = OFF_W'(nxt_right ? nxt_pos - SLOT_POS : nxt_pos);
    assign fmt_cur     = frame_start ? fmt_in : fmt_q;

    // Advance the position, take the format and set the word clock on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= LAST_POS;
            fmt_q <= fmt_in;
            wclk  <= (fmt_in == FMT_LJ);
        end else if (fall_tick) begin
            pos_q <= nxt_pos;
            if (frame_start) fmt_q <= fmt_in;
            wclk  <= (fmt_cur == FMT_LJ) ? ~nxt_right : nxt_right;
        end
    end
endmodule

// File: rtl/amtx_serializer.sv
// Sample holder and serializer.
// Takes one stereo sample per frame in the frame start cycle, or zeros when
// no sample is offered. It then picks the bit for each slot position: MSB
// first, delayed by one bit in I2S, and zero after the LSB.
// Assumes SAMPLE_W < SLOT_BITS.
module amtx_serializer
    import amtx_pkg::*;
#(
    parameter  int SAMPLE_W  = 24,
    parameter  int SLOT_BITS = 32,
    localparam int OFF_W     = $clog2(SLOT_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_tick,
    input  logic                frame_start,
    input  fmt_e                fmt_cur,
    input  logic                nxt_right,
    input  logic [OFF_W-1:0]    nxt_off,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                sdata
);
    logic [SAMPLE_W-1:0] hold_l, hold_r;
    logic [SAMPLE_W-1:0] take_l, take_r;
    logic [SAMPLE_W-1:0] word;
    logic                delay;
    logic                sel_bit;

    assign take_l = smp_valid ? smp_left  : '0;
    assign take_r = smp_valid ? smp_right : '0;
    assign word   = nxt_right ? hold_r : (frame_start ? take_l : hold_l);
    assign delay  = (fmt_cur == FMT_I2S);

    // Choose the word bit that belongs at the coming slot offset.
    always_comb begin
        sel_bit = 1'b0;
        for (int i = 0; i < SAMPLE_W; i++) begin
            if ({1'b0, nxt_off} == (OFF_W+1)'(SAMPLE_W - 1 - i) + {{OFF_W{1'b0}}, delay})
                sel_bit = word[i];
        end
    end

    // Capture the frame's sample and drive the data line on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
            sdata  <= 1'b0;
        end else begin
            if (frame_start) begin
                hold_l <= take_l;
                hold_r <= take_r;
            end
            if (fall_tick) sdata <= sel_bit;
        end
    end
endmodule

// File: rtl/audio_master_tx.sv
// Master serial audio transmitter, top level.
// Generates the bit and word clocks and sends one stereo sample per frame in
// I2S or Left-Justified framing. The sample request is the one-cycle frame
// start strobe. Assumes SAMPLE_W < SLOT_BITS and DIV_HALF >= 1.
module audio_master_tx
    import amtx_pkg::*;
#(
    parameter int DIV_HALF  = 2,
    parameter int SLOT_BITS = 32,
    parameter int SAMPLE_W  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_lj,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                smp_ready,
    output logic                bclk,
    output logic                wclk,
    output logic                sdata
);
    localparam int OFF_W = $clog2(SLOT_BITS);

    logic             fall_tick;
    logic             frame_start;
    fmt_e             fmt_cur;
    logic             nxt_right;
    logic [OFF_W-1:0] nxt_off;

    amtx_bclk_gen #(.DIV_HALF(DIV_HALF)) u_bclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .fall_tick (fall_tick)
    );

    amtx_frame_seq #(.SLOT_BITS(SLOT_BITS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_tick   (fall_tick),
        .fmt_in      (fmt_e'(fmt_lj)),
        .frame_start (frame_start),
        .wclk        (wclk),
        .fmt_cur     (fmt_cur),
        .nxt_right   (nxt_right),
        .nxt_off     (nxt_off)
    );

    amtx_serializer #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_tick   (fall_tick),
        .frame_start (frame_start),
        .fmt_cur     (fmt_cur),
        .nxt_right   (nxt_right),
        .nxt_off     (nxt_off),
        .smp_valid   (smp_valid),
        .smp_left    (smp_left),
        .smp_right   (smp_right),
        .sdata       (sdata)
    );

    assign smp_ready = frame_start;
endmodule

// File: rtl/amtx_checker.sv
// Protocol checker for audio_master_tx, attached with bind.
// Watches only the top-level ports.
module amtx_checker #(
    parameter int SLOT_BITS = 32
) (
    input logic clk,
    input logic rst_n,
    input logic bclk,
    input logic wclk,
    input logic sdata,
    input logic smp_ready
);
    logic        bclk_d, wclk_d;
    logic [15:0] falls_q;
    logic        fell, chg;

    assign fell = bclk_d & ~bclk;
    assign chg  = wclk_d ^ wclk;

    // Count the falling edges that pass without a word clock change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d  <= 1'b0;
            wclk_d  <= wclk;
            falls_q <= '0;
        end else begin
            bclk_d <= bclk;
            wclk_d <= wclk;
            if (fell) falls_q <= chg ? '0 : ((falls_q == 16'hFFFF) ? falls_q : falls_q + 1'b1);
        end
    end

    assert_edge_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(bclk) |-> ($stable(wclk) && $stable(sdata)));

    assert_slot_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bclk) && $changed(wclk)) |-> (falls_q >= 16'(SLOT_BITS - 1)));

    assert_ready_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> $fell(bclk));

    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> !smp_ready);

    assert_reset_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!bclk && !sdata && !smp_ready));
endmodule

bind audio_master_tx amtx_checker #(.SLOT_BITS(SLOT_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk      (bclk),
    .wclk      (wclk),
    .sdata     (sdata),
    .smp_ready (smp_ready)
);

// File: tb/sim_audio_master_tx.sv
`timescale 1ns/1ps
module sim_audio_master_tx;
    localparam int H  = 2;
    localparam int S  = 32;
    localparam int W  = 24;
    localparam int FC = 2 * H * 2 * S;   // system cycles per frame
    localparam int NF = 40;              // frames per phase

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fmt_lj = 1'b0;
    logic smp_valid = 1'b0;
    logic [W-1:0] smp_left = '0, smp_right = '0;
    logic smp_ready, bclk, wclk, sdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] cap_l [0:63];
    logic [W-1:0] cap_r [0:63];
    bit           cap_ok [0:63];
    bit           cap_fmt [0:63];

    always #4 clk = ~clk;

    audio_master_tx #(.DIV_HALF(H), .SLOT_BITS(S), .SAMPLE_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right), .smp_ready(smp_ready),
        .bclk(bclk), .wclk(wclk), .sdata(sdata)
    );

    task automatic check(input string tag, input logic act, input logic exp, input int j);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual=%b expected=%b", tag, j, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int fr, input bit right);
        logic [31:0] v;
        case (fr % 6)
            0: v = right ? 32'h000001 : 32'h800000;
            1: v = right ? 32'h000000 : 32'hFFFFFF;
            2: v = right ? 32'h5A5A5A : 32'hA5A5A5;
            3: v = right ? 32'h0F0F0F : 32'hF0F0F0;
            4: v = right ? 32'hC00003 : 32'h7FFFFE;
            default: v = right ? 32'(fr * 977) : 32'(fr * 40503);
        endcase
        return W'(v);
    endfunction

    task automatic run_phase(input bit rfmt);
        int  fr;
        logic pw, pd;
        rst_n = 1'b0; fmt_lj = rfmt; smp_valid = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R10 reset bclk", bclk, 1'b0, -1);
        check("R10 reset wclk level", wclk, rfmt, -1);
        check("R10 reset sdata", sdata, 1'b0, -1);
        check("R10 reset ready", smp_ready, 1'b0, -1);
        rst_n = 1'b1;
        fr = 0; pw = wclk; pd = sdata;
        for (int j = 0; j < NF * FC; j++) begin
            bit rdy, gap;
            int m, b, f, ch, o, d;
            logic ew, ed;
            logic [W-1:0] wd;
            string tg;
            rdy = ((j + 1) % (2 * H) == 0) && ((((j + 1) / (2 * H)) - 1) % (2 * S) == 0);
            if (j % 1000 == 500) fmt_lj = ~fmt_lj;               // mid-frame change, R9
            if (rdy && (fr % 6 == 2)) fmt_lj = ~fmt_lj;          // change in ready cycle, R9
            gap = (fr % 5 == 3);
            smp_valid = gap ? !rdy : 1'b1;                       // R8: junk offered off the ready cycle
            smp_left  = gap ? W'(32'h123456) : pat(fr, 1'b0);
            smp_right = gap ? W'(32'h654321) : pat(fr, 1'b1);
            if (rdy) begin
                cap_ok[fr] = smp_valid; cap_l[fr] = smp_left;
                cap_r[fr] = smp_right; cap_fmt[fr] = fmt_lj;
                fr++;
            end
            #1;
            // Reference model.
            m = j / (2 * H);
            tg = "R5";
            if (m == 0) begin
                ew = rfmt; ed = 1'b0; f = 0;
            end else begin
                b  = (m - 1) % (2 * S);
                f  = (m - 1) / (2 * S);
                ch = (b >= S) ? 1 : 0;
                o  = b % S;
                d  = o - (cap_fmt[f] ? 0 : 1);
                wd = ch ? cap_r[f] : cap_l[f];
                if (!cap_ok[f]) wd = '0;
                ed = (d >= 0 && d < W) ? wd[W-1-d] : 1'b0;
                ew = cap_fmt[f] ? (ch == 0) : (ch == 1);
                if (!cap_ok[f]) tg = "R8";
                else if (d >= 0 && d < W) tg = cap_fmt[f] ? "R4" : "R3";
                if (cap_fmt[f] != fmt_lj) tg = "R9";
            end
            check("R1 bclk", bclk, logic'((j / H) % 2), j);
            check("R7 ready", smp_ready, rdy, j);
            check((m > 0 && cap_fmt[f] != fmt_lj) ? "R9 wclk" : "R6 wclk", wclk, ew, j);
            check({tg, " sdata"}, sdata, ed, j);
            if (j > 0 && (j % (2 * H)) != 0) begin
                check("R2 wclk hold", wclk, pw, j);
                check("R2 sdata hold", sdata, pd, j);
            end
            pw = wclk; pd = sdata;
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        run_phase(1'b1);
        run_phase(1'b0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule